// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a single clocked register stage for the address and command lines of a memory module. It has a 25-lane data input, a chip-select lane, an on-die-termination lane and a clock-enable lane. Two static strap inputs choose how the captured data reach the output pins. With the width strap low, it is a 25-lane one-to-one register. With the width strap high, it is a 14-lane one-to-two register: each captured lane drives an A copy and a B copy, and the mapping strap picks which data lanes take part.

Two active-low chip-select inputs gate updates of the data outputs. While both are high, the data outputs keep their values. The chip-select, termination and clock-enable lanes are registered on every edge, whatever the state of that gating. An active-low reset clears every output asynchronously. Its release passes through a three-state sequencer (HOLD, SETTLE, RUN), which has the same effect as a two-flop synchronizer. As a result, the outputs stay low until the third rising edge after release.

Sequencer transitions:
- Any state goes to HOLD while reset is low.
- HOLD goes to SETTLE on the first rising edge.
- SETTLE goes to RUN on the second rising edge.
- RUN stays in RUN.

Top module: `rcb_cmd_buffer`

## Requirements
- R1: With width_sel high (pair mode), qb_out equals qa_out. The B lane outputs (cs_qb_n, odt_qb, cke_qb) equal their A lane counterparts.
- R2: The active data lanes are set by the straps, using indices of d_in:
  - width_sel low: lanes 1, 2, 4, 5 and 7 to 24.
  - width_sel high, map_sel low (map A): lanes 1, 2, 4, 5 and 7 to 13.
  - width_sel high, map_sel high (map B): lanes 0 to 5, 7 to 9, 11 and 12.
- R3: Data and control inputs are captured on the rising clock edge and appear on the outputs right after that edge (latency of one edge).
- R4: In RUN, when cs0_n and cs1_n are both high at an edge, the data outputs keep their values. When either is low, the data outputs take the new d_in (masked per R2, R7).
- R5: In RUN, cs_qa_n, odt_qa and cke_qa take cs0_n, odt_in and cke_in at every edge, regardless of the chip-select gating.
- R6: While rst_n is low, all outputs are zero. This takes effect asynchronously, without waiting for a clock edge, and overrides the chip-select gating.
- R7: An inactive data lane (not listed in R2 for the current mode) always outputs zero on both its A and B copies.
- R8: With width_sel low (single mode), qb_out and all B lane control outputs are zero.
- R9: After rst_n rises, the outputs stay zero through the first two rising edges (HOLD to SETTLE, SETTLE to RUN). The first capture happens on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| width_sel | input | 1 | Static strap: 0 = 25-lane single mode, 1 = 14-lane pair mode |
| map_sel | input | 1 | Static strap: lane map in pair mode, 0 = map A, 1 = map B |
| cs0_n | input | 1 | Chip select, active low; also feeds the chip-select lane |
| cs1_n | input | 1 | Second chip select, active low; gates data updates only |
| d_in | input | 25 | Data lanes |
| odt_in | input | 1 | Termination control lane |
| cke_in | input | 1 | Clock-enable lane |
| qa_out | output | 25 | Registered data, A copy |
| qb_out | output | 25 | Registered data, B copy (pair mode only) |
| cs_qa_n | output | 1 | Registered chip select, A copy |
| cs_qb_n | output | 1 | Registered chip select, B copy |
| odt_qa | output | 1 | Registered termination lane, A copy |
| odt_qb | output | 1 | Registered termination lane, B copy |
| cke_qa | output | 1 | Registered clock-enable lane, A copy |
| cke_qb | output | 1 | Registered clock-enable lane, B copy |

## Verification
Each data and control result is due one rising edge after its inputs are presented. The bench therefore drives inputs on a falling edge and compares the outputs on the next falling edge, after exactly one rising edge. The release check counts three rising edges from reset release and expects zeros after the first two and captured values after the third. The asynchronous clear is checked a fraction of a cycle after rst_n falls, with no clock edge in between. Expected values come from a bench model that updates its data copy only when a chip select is low. That model applies fixed per-mode lane masks written as literal constants.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
    localparam int DATA_W = 25;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_PAIR_A = 2'd1,
        MODE_PAIR_B = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SEQ_HOLD   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_RUN    = 2'd2
    } seq_e;

    typedef struct packed {
        logic cs_n;
        logic odt;
        logic cke;
    } ctrl_t;

    function automatic mode_e decode_mode(input logic wide, input logic map_b);
        if (!wide)
            return MODE_SINGLE;
        else if (map_b)
            return MODE_PAIR_B;
        else
            return MODE_PAIR_A;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input mode_e m);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < DATA_W; i++) begin
            unique case (m)
                MODE_SINGLE: v[i] = !(i == 0 || i == 3 || i == 6);
                MODE_PAIR_A: v[i] = (i >= 1) && (i <= 13) && (i != 3) && (i != 6);
                MODE_PAIR_B: v[i] = (i <= 12) && (i != 6) && (i != 10);
                default:     v[i] = 1'b0;
            endcase
        end
        return v;
    endfunction
endpackage

// File: rtl/rcb_rst_seq.sv
module rcb_rst_seq
    import rcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic run
);
    seq_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_HOLD:   state_nx = SEQ_SETTLE;
            SEQ_SETTLE: state_nx = SEQ_RUN;
            SEQ_RUN:    state_nx = SEQ_RUN;
            default:    state_nx = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEQ_HOLD;
        else
            state <= state_nx;
    end

    always_comb begin
        unique case (state)
            SEQ_RUN: run = 1'b1;
            default: run = 1'b0;
        endcase
    end
endmodule

// File: rtl/rcb_lane_bank.sv
module rcb_lane_bank #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/rcb_fanout.sv
module rcb_fanout
    import rcb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  mode_e        mode,
    input  logic [W-1:0] data_q,
    input  ctrl_t        ctrl_q,
    output logic [W-1:0] qa,
    output logic [W-1:0] qb,
    output ctrl_t        ctrl_a,
    output ctrl_t        ctrl_b
);
    logic [W-1:0] mask;
    logic         pair;

    assign mask = lane_mask(mode);
    assign pair = (mode != MODE_SINGLE);

    for (genvar i = 0; i < W; i++) begin : g_lane
        assign qa[i] = data_q[i] & mask[i];
        assign qb[i] = data_q[i] & mask[i] & pair;
    end

    assign ctrl_a = ctrl_q;
    assign ctrl_b = pair ? ctrl_q : '0;
endmodule

// File: rtl/rcb_cmd_buffer.sv
module rcb_cmd_buffer
    import rcb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          width_sel,
    input  logic          map_sel,
    input  logic          cs0_n,
    input  logic          cs1_n,
    input  logic [DW-1:0] d_in,
    input  logic          odt_in,
    input  logic          cke_in,
    output logic [DW-1:0] qa_out,
    output logic [DW-1:0] qb_out,
    output logic          cs_qa_n,
    output logic          cs_qb_n,
    output logic          odt_qa,
    output logic          odt_qb,
    output logic          cke_qa,
    output logic          cke_qb
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic          run;
    logic          data_en;
    mode_e         mode;
    logic [DW-1:0] data_q;
    ctrl_t         ctrl_d, ctrl_q, ctrl_a, ctrl_b;

    assign mode    = decode_mode(width_sel, map_sel);
    assign data_en = !(cs0_n && cs1_n);
    assign ctrl_d  = '{cs_n: cs0_n, odt: odt_in, cke: cke_in};

    rcb_rst_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    rcb_lane_bank #(.W(DW)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .en    (data_en),
        .d     (d_in),
        .q     (data_q)
    );

    rcb_lane_bank #(.W(CTRL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .en    (1'b1),
        .d     (ctrl_d),
        .q     (ctrl_q)
    );

    rcb_fanout #(.W(DW)) u_fan (
        .mode   (mode),
        .data_q (data_q),
        .ctrl_q (ctrl_q),
        .qa     (qa_out),
        .qb     (qb_out),
        .ctrl_a (ctrl_a),
        .ctrl_b (ctrl_b)
    );

    assign cs_qa_n = ctrl_a.cs_n;
    assign odt_qa  = ctrl_a.odt;
    assign cke_qa  = ctrl_a.cke;
    assign cs_qb_n = ctrl_b.cs_n;
    assign odt_qb  = ctrl_b.odt;
    assign cke_qb  = ctrl_b.cke;
endmodule

// File: rtl/rcb_cmd_buffer_chk.sv
module rcb_cmd_buffer_chk
    import rcb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          width_sel,
    input logic          map_sel,
    input logic          cs0_n,
    input logic          cs1_n,
    input logic [DW-1:0] d_in,
    input logic          odt_in,
    input logic          cke_in,
    input logic [DW-1:0] qa_out,
    input logic [DW-1:0] qb_out,
    input logic          cs_qa_n,
    input logic          cs_qb_n,
    input logic          odt_qa,
    input logic          odt_qb,
    input logic          cke_qa,
    input logic          cke_qb,
    input logic          run
);
    logic [DW-1:0] mask;
    assign mask = lane_mask(decode_mode(width_sel, map_sel));

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (qa_out == '0 && qb_out == '0 && !cs_qa_n && !cs_qb_n
                                     && !odt_qa && !odt_qb && !cke_qa && !cke_qb); // R6
        end
    end

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cs0_n && cs1_n) |=> $stable(qa_out)); // R4

    AST_SELECTED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(cs0_n && cs1_n)) |=> (qa_out == ($past(d_in) & mask))); // R3

    AST_CTRL_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cs_qa_n == $past(cs0_n) && odt_qa == $past(odt_in) && cke_qa == $past(cke_in))); // R5

    AST_PAIR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        width_sel |-> (qb_out == qa_out && cs_qb_n == cs_qa_n && odt_qb == odt_qa && cke_qb == cke_qa)); // R1

    AST_SINGLE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !width_sel |-> (qb_out == '0 && !cs_qb_n && !odt_qb && !cke_qb)); // R8

    AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((qa_out & ~mask) == '0)); // R7

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (qa_out == '0 && !cs_qa_n && !odt_qa && !cke_qa)); // R9
endmodule

bind rcb_cmd_buffer rcb_cmd_buffer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .width_sel (width_sel),
    .map_sel   (map_sel),
    .cs0_n     (cs0_n),
    .cs1_n     (cs1_n),
    .d_in      (d_in),
    .odt_in    (odt_in),
    .cke_in    (cke_in),
    .qa_out    (qa_out),
    .qb_out    (qb_out),
    .cs_qa_n   (cs_qa_n),
    .cs_qb_n   (cs_qb_n),
    .odt_qa    (odt_qa),
    .odt_qb    (odt_qb),
    .cke_qa    (cke_qa),
    .cke_qb    (cke_qb),
    .run       (run)
);

// File: tb/rcb_cmd_buffer_bench.sv
`timescale 1ns/1ps
module rcb_cmd_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width_sel = 1'b0, map_sel = 1'b0;
    logic        cs0_n = 1'b1, cs1_n = 1'b1;
    logic [24:0] d_in = '0;
    logic        odt_in = 1'b0, cke_in = 1'b0;
    logic [24:0] qa_out, qb_out;
    logic        cs_qa_n, cs_qb_n, odt_qa, odt_qb, cke_qa, cke_qb;

    int total = 0;
    int bad = 0;

    logic [24:0] m_data;
    logic        m_cs, m_odt, m_cke;

    always #5 clk = ~clk;

    rcb_cmd_buffer u_rcb_cmd_buffer (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .map_sel(map_sel),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .d_in(d_in), .odt_in(odt_in), .cke_in(cke_in),
        .qa_out(qa_out), .qb_out(qb_out), .cs_qa_n(cs_qa_n), .cs_qb_n(cs_qb_n),
        .odt_qa(odt_qa), .odt_qb(odt_qb), .cke_qa(cke_qa), .cke_qb(cke_qb)
    );

    function automatic logic [24:0] mode_mask(input logic wide, input logic mb);
        if (!wide) return 25'h1FFFFB6;
        if (!mb)   return 25'h0003FB6;
        return 25'h0001BBF;
    endfunction

    task automatic check(input string req, input logic [24:0] ea, input logic [24:0] eb,
                         input logic [2:0] eca, input logic [2:0] ecb);
        total++;
        if (qa_out !== ea || qb_out !== eb ||
            {cs_qa_n, odt_qa, cke_qa} !== eca || {cs_qb_n, odt_qb, cke_qb} !== ecb) begin
            bad++;
            $display("FAIL %s: qa=%h qb=%h ca=%b cb=%b expected qa=%h qb=%h ca=%b cb=%b",
                     req, qa_out, qb_out, {cs_qa_n, odt_qa, cke_qa}, {cs_qb_n, odt_qb, cke_qb},
                     ea, eb, eca, ecb);
        end
    endtask

    task automatic check_model(input string req);
        logic [24:0] ea;
        ea = m_data & mode_mask(width_sel, map_sel);
        check(req, ea, width_sel ? ea : 25'h0, {m_cs, m_odt, m_cke},
              width_sel ? {m_cs, m_odt, m_cke} : 3'b000);
    endtask

    task automatic step(input logic [24:0] d, input logic c0, input logic c1,
                        input logic o, input logic k, input string req);
        d_in = d; cs0_n = c0; cs1_n = c1; odt_in = o; cke_in = k;
        @(posedge clk);
        if (!(c0 && c1)) m_data = d;
        m_cs = c0; m_odt = o; m_cke = k;
        @(negedge clk);
        check_model(req);
    endtask

    task automatic run_mode(input logic wide, input logic mb);
        @(negedge clk);
        rst_n = 1'b0;
        width_sel = wide; map_sel = mb;
        m_data = '0; m_cs = 0; m_odt = 0; m_cke = 0;
        // R9: inputs busy while reset releases; two quiet edges, then capture
        d_in = 25'h1FFFFFF; cs0_n = 1'b0; cs1_n = 1'b0; odt_in = 1'b1; cke_in = 1'b1;
        @(negedge clk);
        check("R6 reset state", 25'h0, 25'h0, 3'b000, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 first edge after release", 25'h0, 25'h0, 3'b000, 3'b000);
        @(negedge clk);
        check("R9 second edge after release", 25'h0, 25'h0, 3'b000, 3'b000);
        @(posedge clk);
        m_data = 25'h1FFFFFF; m_cs = 0; m_odt = 1; m_cke = 1;
        @(negedge clk);
        check_model("R9 third edge captures / R2 R7 lane mask");
        // R2 R7 R1 R8: walking one across every lane, gating open
        for (int i = 0; i < 25; i++)
            step(25'h1 << i, i[0], ~i[0], i[1], i[2], "R2 R7 R1 R8 walking lane");
        // R4 R5: gating combinations with changing data
        for (int g = 0; g < 8; g++)
            step((g[0] ? 25'h0AAAAAA : 25'h1555555) ^ (25'(g) << 9), g[1], g[2] | g[0],
                 g[0], ~g[1], "R4 R5 gating sweep");
        step(25'h1FFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R3 all ones");
        step(25'h0000000, 1'b1, 1'b1, 1'b1, 1'b1, "R4 hold with both selects high");
        step(25'h0000000, 1'b1, 1'b1, 1'b0, 1'b1, "R5 control moves during hold");
        step(25'h0000000, 1'b1, 1'b0, 1'b1, 1'b0, "R4 second select loads");
        step(25'h1FFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R4 first select loads");
        // R6: asynchronous clear mid-cycle, selects open
        #2;
        rst_n = 1'b0;
        #1;
        check("R6 asynchronous clear", 25'h0, 25'h0, 3'b000, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_mode(1'b0, 1'b0);
        run_mode(1'b0, 1'b1);
        run_mode(1'b1, 1'b0);
        run_mode(1'b1, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(10 * 50000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule